// File: doc/BRIEF.md
# Phase-Staggered Current-Steered Gate Generator

This block drives the switches of a string of series-connected half-bridge cells in which each cell owns one switch for positive load current and one for negative load current. A single duty command and a single current-direction flag are shared by every cell. Each cell keeps its own carrier counter, and the carriers of the enabled cells are spread evenly over one carrier period. The ripple seen at the string output therefore repeats N times per carrier period. Only the switch that matches the current direction is ever pulsed; its partner in the same cell stays off.

The number of enabled cells is an input and can change while the block runs. The carrier period is a parameter counted in clock cycles (5000 cycles gives a 20 kHz carrier from a 100 MHz clock). Duty and direction are captured per cell at that cell's own carrier wrap, so a command change never cuts a pulse short in the middle of a period.

Top module: `pshift_pwm_gen`

## Requirements
- R1: While `rst_i` is high or `en_i` is low, every gate output is low in that same cycle. On the edge where `en_i` is first seen high, all carriers restart from their start values.
- R2: `cells_i` is clamped to the range 1..MAX_CELLS (0 counts as 1; values above MAX_CELLS count as MAX_CELLS). Cells with index at or above the clamped count keep both gates low.
- R3: With N cells, the lag of cell k is floor(PERIOD*k/N) clock cycles. Its counter restarts at (PERIOD - lag) mod PERIOD and runs 0..PERIOD-1, so cell k reaches zero exactly `lag` cycles after cell 0.
- R4: When the captured direction is 0 (current zero or positive), the cell's positive gate is modulated and its negative gate stays low.
- R5: When the captured direction is 1 (current negative), the cell's negative gate is modulated and its positive gate stays low.
- R6: No cell ever has its positive and negative gate high in the same cycle, including across a direction change.
- R7: The duty command is clamped to PERIOD/2..PERIOD clock cycles; the modulated gate is high while the cell counter is below the clamped duty, so it is high for exactly that many cycles per period.
- R8: Every active cell uses the same duty value and gives the same number of high cycles per period.
- R9: Duty and direction are captured into a cell at a restart and at the edge where that cell's counter wraps from PERIOD-1 to 0; between wraps a cell ignores changes on `duty_i` and `dir_neg_i`.
- R10: A change of the clamped cell count while running restarts every carrier from the start values for the new count, and captures duty and direction at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low forces all gates low |
| duty_i | input | $clog2(PERIOD+1) | Duty command in clock cycles per period |
| dir_neg_i | input | 1 | Current direction: 1 negative, 0 zero or positive |
| cells_i | input | $clog2(MAX_CELLS+1) | Requested number of active cells |
| gate_p_o | output | MAX_CELLS | Positive-current switch gate, one bit per cell |
| gate_n_o | output | MAX_CELLS | Negative-current switch gate, one bit per cell |

## Verification
Gates come combinationally from state registered at the previous edge, so a restart, a counter step or a captured duty shows on the outputs one cycle after the edge that samples the inputs, while a low `en_i` or high `rst_i` clears them in the same cycle. The bench drives inputs on the falling edge, advances an independent timing model at each rising edge from the inputs it drove, and compares both gate vectors at the next falling edge. Phase lags are measured as the number of cycles from the restart edge to each cell's first rising gate, expected at floor(PERIOD*k/N) (PERIOD for cell 0), and duty is checked by counting high cycles over one full period after the shadows have settled.

// File: rtl/pshift_pwm_pkg.sv
package pshift_pwm_pkg;

    typedef enum logic {
        DIR_POS = 1'b0,
        DIR_NEG = 1'b1
    } cur_dir_e;

    function automatic int unsigned clamp_cells(int unsigned raw, int unsigned max_c);
        if (raw == 0)
            return 1;
        else if (raw > max_c)
            return max_c;
        else
            return raw;
    endfunction

    function automatic int unsigned clamp_duty(int unsigned raw, int unsigned period);
        if (raw < period / 2)
            return period / 2;
        else if (raw > period)
            return period;
        else
            return raw;
    endfunction

    function automatic int unsigned cell_lag(int unsigned period, int unsigned k, int unsigned n);
        return (period * k) / n;
    endfunction

    function automatic int unsigned cell_start(int unsigned period, int unsigned k, int unsigned n);
        return (period - cell_lag(period, k, n)) % period;
    endfunction

endpackage

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
    import pshift_pwm_pkg::*;
#(
    parameter int MAX_CELLS = 4,
    parameter int NW        = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic [NW-1:0]        cells_i,
    output logic                 run_o,
    output logic                 restart_o,
    output logic [NW-1:0]        cells_now_o,
    output logic [MAX_CELLS-1:0] active_o
);

    logic          run_q;
    logic [NW-1:0] n_q;

    assign cells_now_o = NW'(clamp_cells(int'(cells_i), MAX_CELLS));
    assign restart_o   = en_i & ~rst_i & (~run_q | (cells_now_o != n_q));
    assign run_o       = run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= 1'b0;
            n_q   <= NW'(1);
        end else if (!en_i) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (restart_o)
                n_q <= cells_now_o;
        end
    end

    for (genvar k = 0; k < MAX_CELLS; k++) begin : g_act
        assign active_o[k] = (NW'(k) < n_q);
    end

    AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        run_q |-> (n_q >= NW'(1) && n_q <= NW'(MAX_CELLS))); // R2

endmodule

// File: rtl/pwm_phase_table.sv
module pwm_phase_table
    import pshift_pwm_pkg::*;
#(
    parameter int PERIOD    = 5000,
    parameter int MAX_CELLS = 4,
    parameter int NW        = 3,
    parameter int CW        = 13
) (
    input  logic [NW-1:0] cells_i,
    output logic [CW-1:0] start_o [MAX_CELLS]
);

    for (genvar k = 0; k < MAX_CELLS; k++) begin : g_cell
        always_comb begin
            start_o[k] = '0;
            for (int n = 1; n <= MAX_CELLS; n++) begin
                if (cells_i == NW'(n))
                    start_o[k] = CW'(cell_start(PERIOD, k, n));
            end
        end
    end

endmodule

// File: rtl/pwm_cell.sv
module pwm_cell
    import pshift_pwm_pkg::*;
#(
    parameter int PERIOD = 5000,
    parameter int CW     = 13,
    parameter int DW     = 13
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          restart_i,
    input  logic          running_i,
    input  logic          active_i,
    input  logic [CW-1:0] start_i,
    input  logic [DW-1:0] duty_i,
    input  cur_dir_e      dir_i,
    output logic          gate_p_o,
    output logic          gate_n_o
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [DW-1:0] duty;
        cur_dir_e      dir;
    } shadow_t;

    logic [CW-1:0] cnt_q;
    shadow_t       sh_q;
    shadow_t       sh_in;
    logic          pulse;

    assign sh_in = '{duty: duty_i, dir: dir_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            sh_q  <= '{duty: '0, dir: DIR_POS};
        end else if (restart_i) begin
            cnt_q <= start_i;
            sh_q  <= sh_in;
        end else if (running_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                sh_q  <= sh_in;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign pulse    = running_i & active_i & (DW'(cnt_q) < sh_q.duty);
    assign gate_p_o = pulse & (sh_q.dir == DIR_POS);
    assign gate_n_o = pulse & (sh_q.dir == DIR_NEG);

    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST); // R3

    AST_RESTART_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(restart_i) |-> (cnt_q == $past(start_i))); // R3

    AST_DUTY_BOUNDS: assert property (@(posedge clk_i) disable iff (rst_i)
        running_i |-> (sh_q.duty >= DW'(PERIOD / 2) && sh_q.duty <= DW'(PERIOD))); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (running_i && $past(running_i) && !$past(restart_i) && cnt_q != '0)
            |-> $stable(sh_q)); // R9

endmodule

// File: rtl/pshift_pwm_gen.sv
module pshift_pwm_gen
    import pshift_pwm_pkg::*;
#(
    parameter int PERIOD    = 5000,
    parameter int MAX_CELLS = 4,
    parameter int DW        = $clog2(PERIOD + 1),
    parameter int NW        = $clog2(MAX_CELLS + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic [DW-1:0]        duty_i,
    input  logic                 dir_neg_i,
    input  logic [NW-1:0]        cells_i,
    output logic [MAX_CELLS-1:0] gate_p_o,
    output logic [MAX_CELLS-1:0] gate_n_o
);

    localparam int CW = $clog2(PERIOD);

    logic                 run;
    logic                 restart;
    logic [NW-1:0]        cells_now;
    logic [MAX_CELLS-1:0] active;
    logic [CW-1:0]        start_val [MAX_CELLS];
    logic [DW-1:0]        duty_c;
    cur_dir_e             dir_c;
    logic [MAX_CELLS-1:0] cell_p;
    logic [MAX_CELLS-1:0] cell_n;
    logic                 out_ok;

    assign duty_c = DW'(clamp_duty(int'(duty_i), PERIOD));
    assign dir_c  = dir_neg_i ? DIR_NEG : DIR_POS;
    assign out_ok = en_i & ~rst_i;

    pwm_seq_ctrl #(
        .MAX_CELLS(MAX_CELLS),
        .NW       (NW)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_i),
        .cells_i    (cells_i),
        .run_o      (run),
        .restart_o  (restart),
        .cells_now_o(cells_now),
        .active_o   (active)
    );

    pwm_phase_table #(
        .PERIOD   (PERIOD),
        .MAX_CELLS(MAX_CELLS),
        .NW       (NW),
        .CW       (CW)
    ) u_table (
        .cells_i(cells_now),
        .start_o(start_val)
    );

    for (genvar k = 0; k < MAX_CELLS; k++) begin : g_cell
        pwm_cell #(
            .PERIOD(PERIOD),
            .CW    (CW),
            .DW    (DW)
        ) u_cell (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .restart_i(restart),
            .running_i(run),
            .active_i (active[k]),
            .start_i  (start_val[k]),
            .duty_i   (duty_c),
            .dir_i    (dir_c),
            .gate_p_o (cell_p[k]),
            .gate_n_o (cell_n[k])
        );
        assign gate_p_o[k] = out_ok & cell_p[k];
        assign gate_n_o[k] = out_ok & cell_n[k];
    end

    AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (gate_p_o & gate_n_o) == '0); // R6

    AST_INACTIVE_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        ((gate_p_o | gate_n_o) & ~active) == '0); // R2

endmodule

// File: tb/sim_pshift_pwm_gen.sv
module sim_pshift_pwm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 40;
    localparam int MAX_CELLS  = 4;
    localparam int DW         = $clog2(PERIOD + 1);
    localparam int NW         = $clog2(MAX_CELLS + 1);

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic                 rst;
    logic                 en;
    logic                 dir_neg;
    logic [DW-1:0]        duty;
    logic [NW-1:0]        cells;
    logic [MAX_CELLS-1:0] gp;
    logic [MAX_CELLS-1:0] gn;

    pshift_pwm_gen #(
        .PERIOD   (PERIOD),
        .MAX_CELLS(MAX_CELLS)
    ) u0 (
        .clk_i    (clk),
        .rst_i    (rst),
        .en_i     (en),
        .duty_i   (duty),
        .dir_neg_i(dir_neg),
        .cells_i  (cells),
        .gate_p_o (gp),
        .gate_n_o (gn)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Independent timing model
    bit m_run = 0;
    int m_n   = 1;
    int m_t   = 0;
    int m_duty [MAX_CELLS];
    bit m_neg  [MAX_CELLS];
    int hp [MAX_CELLS];
    int hn [MAX_CELLS];

    function automatic int want_cells(int raw);
        if (raw < 1) return 1;
        if (raw > MAX_CELLS) return MAX_CELLS;
        return raw;
    endfunction

    function automatic int want_duty(int raw);
        if (raw < PERIOD / 2) return PERIOD / 2;
        if (raw > PERIOD) return PERIOD;
        return raw;
    endfunction

    function automatic int lag(int k);
        return (PERIOD * k) / m_n;
    endfunction

    function automatic int phase_pos(int k);
        return (m_t + PERIOD - lag(k)) % PERIOD;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle time %0t)", tag, act, exp, $time);
        end
    endtask

    task automatic capture(int k);
        m_duty[k] = want_duty(int'(duty));
        m_neg[k]  = dir_neg;
    endtask

    task automatic model_edge();
        int nc;
        nc = want_cells(int'(cells));
        if (rst) begin
            m_run = 0;
            m_n   = 1;
        end else if (!en) begin
            m_run = 0;
        end else if (!m_run || nc != m_n) begin
            m_run = 1;
            m_n   = nc;
            m_t   = 0;
            for (int k = 0; k < MAX_CELLS; k++) capture(k);
        end else begin
            m_t = (m_t + 1) % PERIOD;
            for (int k = 0; k < MAX_CELLS; k++)
                if (phase_pos(k) == 0) capture(k);
        end
    endtask

    task automatic compare();
        logic [MAX_CELLS-1:0] ep;
        logic [MAX_CELLS-1:0] en_v;
        ep   = '0;
        en_v = '0;
        for (int k = 0; k < MAX_CELLS; k++) begin
            if (en && !rst && m_run && k < m_n && phase_pos(k) < m_duty[k]) begin
                if (m_neg[k]) en_v[k] = 1'b1;
                else          ep[k]   = 1'b1;
            end
        end
        chk(gp == ep,   "R4 R7 R9 positive gates", int'(gp), int'(ep));
        chk(gn == en_v, "R5 R7 R9 negative gates", int'(gn), int'(en_v));
        chk((gp & gn) == '0, "R6 gate overlap", int'(gp & gn), 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic count_window();
        for (int k = 0; k < MAX_CELLS; k++) begin
            hp[k] = 0;
            hn[k] = 0;
        end
        repeat (PERIOD) begin
            tick();
            for (int k = 0; k < MAX_CELLS; k++) begin
                hp[k] += int'(gp[k]);
                hn[k] += int'(gn[k]);
            end
        end
    endtask

    task automatic measure_phase(int n);
        logic [MAX_CELLS-1:0] prev;
        int rise [MAX_CELLS];
        cells   = NW'(n);
        duty    = DW'(PERIOD / 2);
        dir_neg = 1'b0;
        en      = 1'b1;
        tick();
        prev = gp;
        for (int k = 0; k < MAX_CELLS; k++) rise[k] = -1;
        for (int i = 1; i <= PERIOD; i++) begin
            tick();
            for (int k = 0; k < MAX_CELLS; k++)
                if (rise[k] < 0 && gp[k] && !prev[k]) rise[k] = i;
            prev = gp;
        end
        for (int k = 0; k < n; k++)
            chk(rise[k] == ((k == 0) ? PERIOD : (PERIOD * k) / n),
                "R3 R10 cell rise after restart", rise[k],
                (k == 0) ? PERIOD : (PERIOD * k) / n);
    endtask

    task automatic settle_and_count(int d, bit neg, int n);
        duty    = DW'(d);
        dir_neg = neg;
        cells   = NW'(n);
        repeat (PERIOD + 1) tick();
        count_window();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst     = 1'b1;
        en      = 1'b0;
        dir_neg = 1'b0;
        duty    = '0;
        cells   = NW'(1);
        repeat (3) tick();
        chk(gp == '0 && gn == '0, "R1 gates low in reset", int'(gp | gn), 0);
        rst = 1'b0;
        tick();
        chk(gp == '0 && gn == '0, "R1 gates low while disabled", int'(gp | gn), 0);

        // R3 / R10: phase lags for each cell count, each change restarts
        measure_phase(2);
        measure_phase(3);
        measure_phase(4);
        measure_phase(1);

        // R7 clamp low and high, R8 equal duty across cells
        settle_and_count(5, 1'b0, 4);
        for (int k = 0; k < MAX_CELLS; k++)
            chk(hp[k] == PERIOD / 2, "R7 floor clamp high count", hp[k], PERIOD / 2);
        settle_and_count(63, 1'b0, 4);
        for (int k = 0; k < MAX_CELLS; k++)
            chk(hp[k] == PERIOD, "R7 ceiling clamp high count", hp[k], PERIOD);
        settle_and_count(30, 1'b0, 4);
        for (int k = 0; k < MAX_CELLS; k++) begin
            chk(hp[k] == 30, "R8 same duty on every cell", hp[k], 30);
            chk(hn[k] == 0, "R4 negative gate idle", hn[k], 0);
        end
        settle_and_count(27, 1'b1, 4);
        for (int k = 0; k < MAX_CELLS; k++) begin
            chk(hn[k] == 27, "R5 negative gate duty", hn[k], 27);
            chk(hp[k] == 0, "R5 positive gate idle", hp[k], 0);
        end

        // R2: cell count clamping
        settle_and_count(25, 1'b0, 0);
        chk(hp[0] == 25, "R2 count 0 keeps cell 0", hp[0], 25);
        for (int k = 1; k < MAX_CELLS; k++)
            chk(hp[k] + hn[k] == 0, "R2 inactive cell low", hp[k] + hn[k], 0);
        settle_and_count(25, 1'b0, 7);
        for (int k = 0; k < MAX_CELLS; k++)
            chk(hp[k] == 25, "R2 count above max uses all cells", hp[k], 25);

        // R9: mid-period duty and direction change ignored until wrap
        cells = NW'(1);
        duty  = DW'(PERIOD);
        dir_neg = 1'b0;
        repeat (PERIOD + 3) tick();
        duty    = DW'(PERIOD / 2);
        dir_neg = 1'b1;
        tick();
        chk(gp[0] == 1'b1 && gn[0] == 1'b0, "R9 change held until wrap",
            int'({gp[0], gn[0]}), 2);

        // R1: enable low clears gates in the same cycle
        duty = DW'(PERIOD);
        repeat (PERIOD + 1) tick();
        en = 1'b0;
        #1;
        chk(gp == '0 && gn == '0, "R1 enable low clears gates", int'(gp | gn), 0);
        repeat (3) tick();
        en = 1'b1;

        // Constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            if (r < 200) duty = DW'($urandom_range(0, (1 << DW) - 1));
            if (r >= 200 && r < 300) dir_neg = ~dir_neg;
            if (r >= 300 && r < 310) cells = NW'($urandom_range(0, (1 << NW) - 1));
            if (r >= 310 && r < 315) en = ~en;
            if (r >= 315 && r < 317) rst = 1'b1;
            else rst = 1'b0;
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule